// File: doc/BRIEF.md
# Token-Counting Cache Line Controller

This block is the per-node coherence agent in a system where write and read permission on a cache line is decided by counting tokens rather than by an ordered bus or a directory. Each line has a fixed system-wide pool of `TOKENS` tokens. One of them is the owner token. Tokens only move between nodes and are never created or destroyed. The controller keeps the tokens this node holds in a small fully associative table. Each entry has a token count, an owner flag, a data-valid flag and a written flag. An entry is free when its count is zero.

A local load or store is granted in the same cycle in which the held tokens allow it. When they do not, the controller broadcasts a transient request and starts a timeout. If the timeout expires before permission arrives, it raises a persistent request. Other nodes must then forward every token they hold for that line.

The controller also answers other nodes:
- Read requests are answered with one token, or with all tokens when the line was written locally (migratory sharing).
- Write requests are answered with all tokens.
- While another node's persistent request is active, this node forwards to that node everything it holds for the line.

Any message that carries the owner token also carries the data.

Top module: `tokline_ctrl`

## Requirements
- R1: After reset every line reads back Invalid with zero tokens. No grant, transient request, persistent message or response is driven.
- R2: The reported line state is 2 (Modified) when the node holds all `TOKENS` tokens, 1 (Shared) when it holds some but not all, and 0 (Invalid) when it holds none.
- R3: Tokens arriving in a response add to the count already held for the line. A new line takes a free entry. No count ever exceeds `TOKENS`.
- R4: A response that carries tokens but no data does not mark the copy valid, so a local load on that line is not granted.
- R5: A local store is granted only while all `TOKENS` tokens are held. A local load is granted only while at least one token is held and the data is valid. Both are granted in the cycle the condition holds.
- R6: Every outgoing response that carries the owner token also carries data.
- R7: On an incoming read request for a line that has not been written locally:
  - With more than one token held, the node sends one non-owner token without data.
  - With only the owner token held, it sends that token with data and goes Invalid.
  - With a single non-owner token held, it sends nothing.
- R8: On an incoming write request the node sends every token it holds, with data if the owner token is among them, and the line becomes Invalid.
- R9: An incoming read request for a line written locally is answered with all held tokens, and the line becomes Invalid.
- R10: A local request that cannot be granted immediately issues exactly one transient broadcast in its first cycle. If it is still not granted, a persistent activate pulse follows exactly `TIMEOUT` cycles later. The count restarts for every new request, and activate and deactivate are never driven together.
- R11: A persistent deactivate is issued in the cycle the persistent local request is granted, or when the requester withdraws it.
- R12: While another node's persistent request is active for a line, the node forwards all tokens it holds for that line, including tokens that arrive later, to that node, and grants no local access to the line. A deactivate message ends this.
- R13: A response for a line that has no entry when the table is full is sent on to node `HOME_ID` unchanged (same tokens, owner and data).
- R14: In a cycle with an incoming response, the response is the only table update. An incoming request in that cycle is dropped without a reply, leaving the requested line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lreq_valid | input | 1 | Local access request, held until granted or withdrawn |
| lreq_write | input | 1 | 1 = store, 0 = load |
| lreq_addr | input | AW | Line address of the local access |
| lgrant | output | 1 | Local access completes this cycle |
| oreq_valid | output | 1 | Transient broadcast request |
| oreq_write | output | 1 | Transient request is for write permission |
| oreq_addr | output | AW | Transient request line |
| ireq_valid | input | 1 | Incoming request from another node |
| ireq_write | input | 1 | Incoming request wants write permission |
| ireq_addr | input | AW | Incoming request line |
| ireq_src | input | NW | Requesting node |
| irsp_valid | input | 1 | Incoming token response |
| irsp_addr | input | AW | Response line |
| irsp_tokens | input | CW | Tokens carried |
| irsp_owner | input | 1 | Owner token included |
| irsp_data | input | 1 | Data included |
| pact_valid | input | 1 | Another node activates a persistent request |
| pact_addr | input | AW | Line of that persistent request |
| pact_src | input | NW | Node that raised it |
| pdeact_valid | input | 1 | The active remote persistent request ends |
| orsp_valid | output | 1 | Outgoing token response |
| orsp_addr | output | AW | Outgoing response line |
| orsp_dest | output | NW | Destination node |
| orsp_tokens | output | CW | Tokens sent |
| orsp_owner | output | 1 | Owner token sent |
| orsp_data | output | 1 | Data sent |
| opers_act | output | 1 | Persistent request activate for the local line |
| opers_deact | output | 1 | Persistent request deactivate for the local line |
| opers_addr | output | AW | Line of the local persistent request |
| st_addr | input | AW | Line whose state is reported |
| st_state | output | 2 | 0 Invalid, 1 Shared, 2 Modified |
| st_tokens | output | CW | Tokens held for `st_addr` |
| st_owner | output | 1 | Owner token held for `st_addr` |
| st_valid | output | 1 | Data valid for `st_addr` |

## Verification
The request-answering path is driven with read requests against lines holding four tokens, only the owner token, two non-owner tokens and a single non-owner token. These cases separate the one-token, owner-with-data and silent replies. Written lines and write requests show the all-token reply. Responses with and without data show that validity follows data and not token count. A response into a full table checks the redirect to home, and a response colliding with a request checks that the request is dropped. Timed local misses check the exact timeout, the restart on a new request and both deactivate causes. A remote persistent request checks forwarding of both held and newly arrived tokens, and that local access to the line stays blocked until deactivation.

// File: rtl/tok_pkg.sv
package tok_pkg;
  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_M = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    LR_IDLE = 2'd0,
    LR_WAIT = 2'd1,
    LR_PERS = 2'd2
  } lreq_st_e;
endpackage

// File: rtl/tok_lookup.sv
module tok_lookup #(
  parameter int ENTRIES = 4,
  parameter int AW      = 8,
  parameter int IDXW    = 2
) (
  input  logic [ENTRIES-1:0][AW-1:0] tags,
  input  logic [ENTRIES-1:0]         live,
  input  logic [AW-1:0]              addr,
  output logic                       hit,
  output logic [IDXW-1:0]            idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (live[i] && (tags[i] == addr)) begin
        hit = 1'b1;
        idx = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/tok_reqfsm.sv
module tok_reqfsm
  import tok_pkg::*;
#(
  parameter int TIMEOUT = 8,
  localparam int TW = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic perm,
  output logic grant,
  output logic issue,
  output logic act,
  output logic deact,
  output logic in_pers
);
  lreq_st_e st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic tmr_en;

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q;
    tmr_en = 1'b0;
    issue  = 1'b0;
    act    = 1'b0;
    deact  = 1'b0;
    grant  = req && perm;
    unique case (st_q)
      LR_IDLE: begin
        if (req && !perm) begin
          issue  = 1'b1;
          st_d   = LR_WAIT;
          tmr_d  = '0;
          tmr_en = 1'b1;
        end
      end
      LR_WAIT: begin
        if (!req || perm) begin
          st_d = LR_IDLE;
        end else if (tmr_q == TW'(TIMEOUT - 1)) begin
          act  = 1'b1;
          st_d = LR_PERS;
        end else begin
          tmr_d  = tmr_q + TW'(1);
          tmr_en = 1'b1;
        end
      end
      LR_PERS: begin
        if (!req || perm) begin
          deact = 1'b1;
          st_d  = LR_IDLE;
        end
      end
      default: st_d = LR_IDLE;
    endcase
  end

  assign in_pers = (st_q == LR_PERS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LR_IDLE;
      tmr_q <= '0;
    end else begin
      st_q <= st_d;
      if (tmr_en) tmr_q <= tmr_d;
    end
  end
endmodule

// File: rtl/tokline_ctrl.sv
module tokline_ctrl
  import tok_pkg::*;
#(
  parameter int TOKENS  = 4,
  parameter int ENTRIES = 4,
  parameter int AW      = 8,
  parameter int NW      = 2,
  parameter int TIMEOUT = 8,
  parameter int HOME_ID = 0,
  localparam int CW   = $clog2(TOKENS + 1),
  localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lreq_valid,
  input  logic          lreq_write,
  input  logic [AW-1:0] lreq_addr,
  output logic          lgrant,
  output logic          oreq_valid,
  output logic          oreq_write,
  output logic [AW-1:0] oreq_addr,
  input  logic          ireq_valid,
  input  logic          ireq_write,
  input  logic [AW-1:0] ireq_addr,
  input  logic [NW-1:0] ireq_src,
  input  logic          irsp_valid,
  input  logic [AW-1:0] irsp_addr,
  input  logic [CW-1:0] irsp_tokens,
  input  logic          irsp_owner,
  input  logic          irsp_data,
  input  logic          pact_valid,
  input  logic [AW-1:0] pact_addr,
  input  logic [NW-1:0] pact_src,
  input  logic          pdeact_valid,
  output logic          orsp_valid,
  output logic [AW-1:0] orsp_addr,
  output logic [NW-1:0] orsp_dest,
  output logic [CW-1:0] orsp_tokens,
  output logic          orsp_owner,
  output logic          orsp_data,
  output logic          opers_act,
  output logic          opers_deact,
  output logic [AW-1:0] opers_addr,
  input  logic [AW-1:0] st_addr,
  output logic [1:0]    st_state,
  output logic [CW-1:0] st_tokens,
  output logic          st_owner,
  output logic          st_valid
);
  localparam int NLK = 5;
  localparam int LK_LOC = 0;
  localparam int LK_REQ = 1;
  localparam int LK_RSP = 2;
  localparam int LK_PER = 3;
  localparam int LK_ST  = 4;

  // reset: asserted asynchronously, released after two clock edges
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  logic [ENTRIES-1:0][AW-1:0] tag_q, tag_d;
  logic [ENTRIES-1:0][CW-1:0] cnt_q, cnt_d;
  logic [ENTRIES-1:0]         own_q, own_d, val_q, val_d, wr_q, wr_d;
  logic [ENTRIES-1:0]         live;
  logic                       per_on_q, per_on_d;
  logic [AW-1:0]              per_addr_q, per_addr_d;
  logic [NW-1:0]              per_dst_q, per_dst_d;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) live[i] = (cnt_q[i] != '0);
  end

  // parallel associative lookups, one per address source
  logic [NLK-1:0][AW-1:0]   lk_addr;
  logic [NLK-1:0]           lk_hit;
  logic [NLK-1:0][IDXW-1:0] lk_idx;

  assign lk_addr[LK_LOC] = lreq_addr;
  assign lk_addr[LK_REQ] = ireq_addr;
  assign lk_addr[LK_RSP] = irsp_addr;
  assign lk_addr[LK_PER] = per_addr_q;
  assign lk_addr[LK_ST]  = st_addr;

  for (genvar g = 0; g < NLK; g++) begin : gen_lk
    tok_lookup #(.ENTRIES(ENTRIES), .AW(AW), .IDXW(IDXW)) u_lk (
      .tags (tag_q),
      .live (live),
      .addr (lk_addr[g]),
      .hit  (lk_hit[g]),
      .idx  (lk_idx[g])
    );
  end

  logic            l_hit, rq_hit, rsp_hit, per_hit, st_hit;
  logic [IDXW-1:0] l_idx, rq_idx, rsp_idx, per_idx, st_idx;
  assign l_hit   = lk_hit[LK_LOC];
  assign l_idx   = lk_idx[LK_LOC];
  assign rq_hit  = lk_hit[LK_REQ];
  assign rq_idx  = lk_idx[LK_REQ];
  assign rsp_hit = lk_hit[LK_RSP];
  assign rsp_idx = lk_idx[LK_RSP];
  assign per_hit = lk_hit[LK_PER];
  assign per_idx = lk_idx[LK_PER];
  assign st_hit  = lk_hit[LK_ST];
  assign st_idx  = lk_idx[LK_ST];

  // lowest free entry
  logic            free_any;
  logic [IDXW-1:0] free_idx;
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!live[i]) begin
        free_any = 1'b1;
        free_idx = IDXW'(i);
      end
    end
  end

  // local permission
  logic [CW-1:0] l_cnt;
  logic          l_val, pers_blk, perm, fsm_pers;
  assign l_cnt    = l_hit ? cnt_q[l_idx] : '0;
  assign l_val    = l_hit && val_q[l_idx];
  assign pers_blk = per_on_q && (per_addr_q == lreq_addr);
  assign perm     = l_hit && !pers_blk &&
                    (lreq_write ? (l_cnt == CW'(TOKENS)) : val_q[l_idx]);

  tok_reqfsm #(.TIMEOUT(TIMEOUT)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_q),
    .req     (lreq_valid),
    .perm    (perm),
    .grant   (lgrant),
    .issue   (oreq_valid),
    .act     (opers_act),
    .deact   (opers_deact),
    .in_pers (fsm_pers)
  );

  assign oreq_write = lreq_write;
  assign oreq_addr  = lreq_addr;
  assign opers_addr = lreq_addr;

  // remote persistent request register
  always_comb begin
    per_on_d   = per_on_q;
    per_addr_d = per_addr_q;
    per_dst_d  = per_dst_q;
    if (pact_valid) begin
      per_on_d   = 1'b1;
      per_addr_d = pact_addr;
      per_dst_d  = pact_src;
    end else if (pdeact_valid) begin
      per_on_d = 1'b0;
    end
  end

  // table update and outgoing responses
  logic per_fwd, req_blk, tbl_en;
  assign per_fwd = per_on_q && per_hit;
  assign req_blk = (ireq_addr == lreq_addr) && (lgrant || fsm_pers);
  assign tbl_en  = irsp_valid || per_fwd || ireq_valid || lgrant;

  always_comb begin
    tag_d       = tag_q;
    cnt_d       = cnt_q;
    own_d       = own_q;
    val_d       = val_q;
    wr_d        = wr_q;
    orsp_valid  = 1'b0;
    orsp_addr   = '0;
    orsp_dest   = '0;
    orsp_tokens = '0;
    orsp_owner  = 1'b0;
    orsp_data   = 1'b0;
    if (irsp_valid) begin
      if (rsp_hit) begin
        cnt_d[rsp_idx] = cnt_q[rsp_idx] + irsp_tokens;
        own_d[rsp_idx] = own_q[rsp_idx] | irsp_owner;
        val_d[rsp_idx] = val_q[rsp_idx] | irsp_data;
      end else if (free_any) begin
        tag_d[free_idx] = irsp_addr;
        cnt_d[free_idx] = irsp_tokens;
        own_d[free_idx] = irsp_owner;
        val_d[free_idx] = irsp_data;
        wr_d[free_idx]  = 1'b0;
      end else begin
        orsp_valid  = 1'b1;
        orsp_addr   = irsp_addr;
        orsp_dest   = NW'(HOME_ID);
        orsp_tokens = irsp_tokens;
        orsp_owner  = irsp_owner;
        orsp_data   = irsp_data;
      end
    end else if (per_fwd) begin
      orsp_valid       = 1'b1;
      orsp_addr        = per_addr_q;
      orsp_dest        = per_dst_q;
      orsp_tokens      = cnt_q[per_idx];
      orsp_owner       = own_q[per_idx];
      orsp_data        = own_q[per_idx];
      cnt_d[per_idx]   = '0;
      own_d[per_idx]   = 1'b0;
      val_d[per_idx]   = 1'b0;
      wr_d[per_idx]    = 1'b0;
    end else if (ireq_valid && rq_hit && !req_blk) begin
      if (ireq_write || wr_q[rq_idx] ||
          (cnt_q[rq_idx] == CW'(1) && own_q[rq_idx])) begin
        orsp_valid     = 1'b1;
        orsp_addr      = ireq_addr;
        orsp_dest      = ireq_src;
        orsp_tokens    = cnt_q[rq_idx];
        orsp_owner     = own_q[rq_idx];
        orsp_data      = own_q[rq_idx];
        cnt_d[rq_idx]  = '0;
        own_d[rq_idx]  = 1'b0;
        val_d[rq_idx]  = 1'b0;
        wr_d[rq_idx]   = 1'b0;
      end else if (cnt_q[rq_idx] > CW'(1)) begin
        orsp_valid     = 1'b1;
        orsp_addr      = ireq_addr;
        orsp_dest      = ireq_src;
        orsp_tokens    = CW'(1);
        cnt_d[rq_idx]  = cnt_q[rq_idx] - CW'(1);
      end
    end
    if (lgrant && lreq_write) wr_d[l_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      tag_q      <= '0;
      cnt_q      <= '0;
      own_q      <= '0;
      val_q      <= '0;
      wr_q       <= '0;
      per_on_q   <= 1'b0;
      per_addr_q <= '0;
      per_dst_q  <= '0;
    end else begin
      if (tbl_en) begin
        tag_q <= tag_d;
        cnt_q <= cnt_d;
        own_q <= own_d;
        val_q <= val_d;
        wr_q  <= wr_d;
      end
      if (pact_valid || pdeact_valid) begin
        per_on_q   <= per_on_d;
        per_addr_q <= per_addr_d;
        per_dst_q  <= per_dst_d;
      end
    end
  end

  // state report
  logic [CW-1:0] st_cnt;
  assign st_cnt    = st_hit ? cnt_q[st_idx] : '0;
  assign st_tokens = st_cnt;
  assign st_owner  = st_hit && own_q[st_idx];
  assign st_valid  = st_hit && val_q[st_idx];
  always_comb begin
    if (st_cnt == CW'(TOKENS))  st_state = LINE_M;
    else if (st_cnt != '0)      st_state = LINE_S;
    else                        st_state = LINE_I;
  end
endmodule

// File: rtl/tok_checker.sv
module tok_checker #(
  parameter int TOKENS  = 4,
  parameter int ENTRIES = 4,
  parameter int CW      = 3,
  parameter int IDXW    = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       lreq_valid,
  input logic                       lreq_write,
  input logic                       lgrant,
  input logic [CW-1:0]              l_cnt,
  input logic                       l_val,
  input logic                       orsp_valid,
  input logic                       orsp_owner,
  input logic                       orsp_data,
  input logic                       irsp_valid,
  input logic                       irsp_data,
  input logic                       rsp_hit,
  input logic [IDXW-1:0]            rsp_idx,
  input logic [ENTRIES-1:0]         val_vec,
  input logic [ENTRIES-1:0][CW-1:0] cnt_vec,
  input logic                       opers_act,
  input logic                       opers_deact
);
  for (genvar i = 0; i < ENTRIES; i++) begin : gen_bound
    // R3: a held count never exceeds the system total
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_vec[i] <= CW'(TOKENS));
  end

  // R4: tokens without data leave an invalid copy invalid
  a_r4_nodata_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (irsp_valid && !irsp_data && rsp_hit && !val_vec[rsp_idx])
      |=> !val_vec[$past(rsp_idx)]);

  // R5: store grant needs every token
  a_r5_store_full: assert property (@(posedge clk) disable iff (!rst_n)
    (lgrant && lreq_write) |-> (l_cnt == CW'(TOKENS)));

  // R5: load grant needs a token and valid data
  a_r5_load_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (lgrant && !lreq_write) |-> (l_cnt != '0 && l_val));

  // R6: owner token always travels with data
  a_r6_owner_data: assert property (@(posedge clk) disable iff (!rst_n)
    (orsp_valid && orsp_owner) |-> orsp_data);

  // R10: activate and deactivate are exclusive
  a_r10_act_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(opers_act && opers_deact));

  // R11: deactivate only on completion or withdrawal
  a_r11_deact_cause: assert property (@(posedge clk) disable iff (!rst_n)
    opers_deact |-> (lgrant || !lreq_valid));
endmodule

bind tokline_ctrl tok_checker #(
  .TOKENS(TOKENS), .ENTRIES(ENTRIES), .CW(CW), .IDXW(IDXW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_q),
  .lreq_valid  (lreq_valid),
  .lreq_write  (lreq_write),
  .lgrant      (lgrant),
  .l_cnt       (l_cnt),
  .l_val       (l_val),
  .orsp_valid  (orsp_valid),
  .orsp_owner  (orsp_owner),
  .orsp_data   (orsp_data),
  .irsp_valid  (irsp_valid),
  .irsp_data   (irsp_data),
  .rsp_hit     (rsp_hit),
  .rsp_idx     (rsp_idx),
  .val_vec     (val_q),
  .cnt_vec     (cnt_q),
  .opers_act   (opers_act),
  .opers_deact (opers_deact)
);

// File: tb/tokline_ctrl_test.sv
`timescale 1ns/1ps
module tokline_ctrl_test;
  localparam int T   = 4;
  localparam int TO  = 8;
  localparam int AW  = 8;
  localparam int NW  = 2;
  localparam int CW  = $clog2(T + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic lreq_valid, lreq_write;  logic [AW-1:0] lreq_addr;
  logic lgrant, oreq_valid, oreq_write; logic [AW-1:0] oreq_addr;
  logic ireq_valid, ireq_write; logic [AW-1:0] ireq_addr; logic [NW-1:0] ireq_src;
  logic irsp_valid; logic [AW-1:0] irsp_addr; logic [CW-1:0] irsp_tokens;
  logic irsp_owner, irsp_data;
  logic pact_valid; logic [AW-1:0] pact_addr; logic [NW-1:0] pact_src; logic pdeact_valid;
  logic orsp_valid; logic [AW-1:0] orsp_addr; logic [NW-1:0] orsp_dest;
  logic [CW-1:0] orsp_tokens; logic orsp_owner, orsp_data;
  logic opers_act, opers_deact; logic [AW-1:0] opers_addr;
  logic [AW-1:0] st_addr; logic [1:0] st_state; logic [CW-1:0] st_tokens;
  logic st_owner, st_valid;

  int n_chk = 0;
  int n_fail = 0;
  int r_v, r_t, r_o, r_d, r_dst;

  always #5 clk = ~clk;

  tokline_ctrl #(.TOKENS(T), .ENTRIES(4), .AW(AW), .NW(NW), .TIMEOUT(TO), .HOME_ID(0)) uut (
    .clk(clk), .rst_n(rst_n),
    .lreq_valid(lreq_valid), .lreq_write(lreq_write), .lreq_addr(lreq_addr), .lgrant(lgrant),
    .oreq_valid(oreq_valid), .oreq_write(oreq_write), .oreq_addr(oreq_addr),
    .ireq_valid(ireq_valid), .ireq_write(ireq_write), .ireq_addr(ireq_addr), .ireq_src(ireq_src),
    .irsp_valid(irsp_valid), .irsp_addr(irsp_addr), .irsp_tokens(irsp_tokens),
    .irsp_owner(irsp_owner), .irsp_data(irsp_data),
    .pact_valid(pact_valid), .pact_addr(pact_addr), .pact_src(pact_src), .pdeact_valid(pdeact_valid),
    .orsp_valid(orsp_valid), .orsp_addr(orsp_addr), .orsp_dest(orsp_dest),
    .orsp_tokens(orsp_tokens), .orsp_owner(orsp_owner), .orsp_data(orsp_data),
    .opers_act(opers_act), .opers_deact(opers_deact), .opers_addr(opers_addr),
    .st_addr(st_addr), .st_state(st_state), .st_tokens(st_tokens),
    .st_owner(st_owner), .st_valid(st_valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic next;
    @(negedge clk);
    #1;
  endtask

  task automatic clr_in;
    lreq_valid = 0; lreq_write = 0; lreq_addr = '0;
    ireq_valid = 0; ireq_write = 0; ireq_addr = '0; ireq_src = '0;
    irsp_valid = 0; irsp_addr = '0; irsp_tokens = '0; irsp_owner = 0; irsp_data = 0;
    pact_valid = 0; pact_addr = '0; pact_src = '0; pdeact_valid = 0;
    st_addr = '0;
  endtask

  task automatic line_chk(input string tag, input int a, input int est, input int ecnt);
    st_addr = AW'(a);
    #1;
    chk({tag, " state"}, int'(st_state), est);
    chk({tag, " tokens"}, int'(st_tokens), ecnt);
  endtask

  task automatic give(input int a, input int t, input bit o, input bit d);
    next;
    irsp_valid = 1; irsp_addr = AW'(a); irsp_tokens = CW'(t); irsp_owner = o; irsp_data = d;
    #1;
    next;
    irsp_valid = 0;
    #1;
  endtask

  task automatic ask(input bit w, input int a, input int src);
    next;
    ireq_valid = 1; ireq_write = w; ireq_addr = AW'(a); ireq_src = NW'(src);
    #1;
    r_v = orsp_valid; r_t = orsp_tokens; r_o = orsp_owner; r_d = orsp_data; r_dst = orsp_dest;
    next;
    ireq_valid = 0;
    #1;
  endtask

  task automatic t_reset;
    line_chk("R1 reset", 'h10, 0, 0);
    chk("R1 lgrant", lgrant, 0);
    chk("R1 orsp", orsp_valid, 0);
    chk("R1 oreq", oreq_valid, 0);
    chk("R1 opers", opers_act | opers_deact, 0);
  endtask

  task automatic t_fill;
    give('h10, 3, 1, 1);
    line_chk("R2 shared", 'h10, 1, 3);
    give('h10, 1, 0, 0);
    line_chk("R3 accumulate", 'h10, 2, 4);
    chk("R3 valid kept", st_valid, 1);
  endtask

  task automatic t_nodata;
    give('h20, 2, 0, 0);
    line_chk("R4 nodata", 'h20, 1, 2);
    chk("R4 valid", st_valid, 0);
    next;
    lreq_valid = 1; lreq_write = 0; lreq_addr = 'h20;
    #1;
    chk("R4 load refused", lgrant, 0);
    chk("R10 transient issued", oreq_valid, 1);
    next;
    lreq_valid = 0;
  endtask

  task automatic t_local;
    next;
    lreq_valid = 1; lreq_write = 1; lreq_addr = 'h10;
    #1;
    chk("R5 store granted", lgrant, 1);
    chk("R5 no transient", oreq_valid, 0);
    next;
    lreq_write = 0;
    #1;
    chk("R5 load granted", lgrant, 1);
    next;
    lreq_write = 1; lreq_addr = 'h20;
    #1;
    chk("R5 store partial refused", lgrant, 0);
    next;
    lreq_valid = 0;
  endtask

  task automatic t_migratory;
    ask(0, 'h10, 2);
    chk("R9 sends", r_v, 1);
    chk("R9 all tokens", r_t, 4);
    chk("R6 owner data", r_o + r_d, 2);
    chk("R9 dest", r_dst, 2);
    line_chk("R9 after", 'h10, 0, 0);
  endtask

  task automatic t_readshare;
    give('h30, 4, 1, 1);
    ask(0, 'h30, 1);
    chk("R7 one token", r_t, 1);
    chk("R7 non-owner no data", r_o + r_d, 0);
    line_chk("R7 keeps", 'h30, 1, 3);
    give('h40, 1, 1, 1);
    ask(0, 'h40, 3);
    chk("R7 owner only sent", r_t, 1);
    chk("R7 owner+data", r_o + r_d, 2);
    line_chk("R7 owner gone", 'h40, 0, 0);
    ask(0, 'h20, 1);
    chk("R7 two nonowner one sent", r_t, 1);
    line_chk("R7 one left", 'h20, 1, 1);
    ask(0, 'h20, 1);
    chk("R7 single nonowner silent", r_v, 0);
    line_chk("R7 single kept", 'h20, 1, 1);
  endtask

  task automatic t_writereq;
    ask(1, 'h30, 3);
    chk("R8 all tokens", r_t, 3);
    chk("R8 owner data", r_o + r_d, 2);
    chk("R8 dest", r_dst, 3);
    line_chk("R8 invalid", 'h30, 0, 0);
    ask(1, 'h20, 2);
    chk("R8 nonowner only", r_t, 1);
    chk("R8 no data", r_d, 0);
  endtask

  task automatic t_full;
    for (int i = 0; i < 4; i++) give('h80 + i, 1, 0, 0);
    next;
    irsp_valid = 1; irsp_addr = 'h90; irsp_tokens = 2; irsp_owner = 1; irsp_data = 1;
    #1;
    chk("R13 bounce", orsp_valid, 1);
    chk("R13 home", orsp_dest, 0);
    chk("R13 tokens", orsp_tokens, 2);
    chk("R13 owner data", orsp_owner + orsp_data, 2);
    next;
    irsp_valid = 0;
    #1;
    line_chk("R13 not held", 'h90, 0, 0);
    for (int i = 0; i < 4; i++) begin
      ask(1, 'h80 + i, 1);
      chk("R8 drain", r_t, 1);
    end
  endtask

  task automatic t_drop;
    give('h50, 4, 1, 1);
    next;
    irsp_valid = 1; irsp_addr = 'h51; irsp_tokens = 1; irsp_owner = 0; irsp_data = 0;
    ireq_valid = 1; ireq_write = 1; ireq_addr = 'h50; ireq_src = 2;
    #1;
    chk("R14 request dropped", orsp_valid, 0);
    next;
    clr_in;
    #1;
    line_chk("R14 line kept", 'h50, 2, 4);
    line_chk("R14 response taken", 'h51, 1, 1);
    ask(1, 'h50, 2);
    chk("R8 clear G", r_t, 4);
    ask(1, 'h51, 2);
    chk("R8 clear H", r_t, 1);
  endtask

  task automatic t_timeout;
    int n;
    next;
    lreq_valid = 1; lreq_write = 1; lreq_addr = 'h70;
    #1;
    chk("R10 issue", oreq_valid, 1);
    n = 0;
    for (int k = 1; k <= 3 * TO; k++) begin
      next;
      if (oreq_valid) chk("R10 single transient", 1, 0);
      if (opers_act) begin n = k; break; end
    end
    chk("R10 timeout cycles", n, TO);
    next;
    irsp_valid = 1; irsp_addr = 'h70; irsp_tokens = 4; irsp_owner = 1; irsp_data = 1;
    #1;
    next;
    irsp_valid = 0;
    #1;
    chk("R11 grant", lgrant, 1);
    chk("R11 deact on grant", opers_deact, 1);
    next;
    lreq_valid = 0;
    lreq_addr = 'h71;
    lreq_valid = 1;
    #1;
    chk("R10 restart issue", oreq_valid, 1);
    n = 0;
    for (int k = 1; k <= 3 * TO; k++) begin
      next;
      if (opers_act) begin n = k; break; end
    end
    chk("R10 restart cycles", n, TO);
    next;
    lreq_valid = 0;
    #1;
    chk("R11 deact on withdraw", opers_deact, 1);
    ask(0, 'h70, 1);
    chk("R9 written line all", r_t, 4);
  endtask

  task automatic t_remote;
    give('h60, 4, 1, 1);
    next;
    pact_valid = 1; pact_addr = 'h60; pact_src = 3;
    #1;
    next;
    pact_valid = 0;
    #1;
    chk("R12 forward", orsp_valid, 1);
    chk("R12 forward all", orsp_tokens, 4);
    chk("R12 forward dest", orsp_dest, 3);
    next;
    line_chk("R12 emptied", 'h60, 0, 0);
    lreq_valid = 1; lreq_write = 0; lreq_addr = 'h60;
    #1;
    chk("R12 miss", lgrant, 0);
    next;
    irsp_valid = 1; irsp_addr = 'h60; irsp_tokens = 2; irsp_owner = 1; irsp_data = 1;
    #1;
    next;
    irsp_valid = 0;
    #1;
    chk("R12 late tokens forwarded", orsp_tokens, 2);
    chk("R12 local blocked", lgrant, 0);
    next;
    pdeact_valid = 1;
    #1;
    next;
    pdeact_valid = 0;
    irsp_valid = 1; irsp_addr = 'h60; irsp_tokens = 2; irsp_owner = 1; irsp_data = 1;
    #1;
    next;
    irsp_valid = 0;
    #1;
    chk("R12 kept after deact", orsp_valid, 0);
    chk("R12 load after deact", lgrant, 1);
    next;
    lreq_valid = 0;
    ask(1, 'h60, 1);
    chk("R8 clear P", r_t, 2);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 0 expected 1");
    summary();
  end

  initial begin
    clr_in;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    t_reset;
    t_fill;
    t_nodata;
    t_local;
    t_migratory;
    t_readshare;
    t_writereq;
    t_full;
    t_drop;
    t_timeout;
    t_remote;
    next;
    summary();
  end
endmodule